// File: doc/BRIEF.md
# Sprite Pixel Priority Mixer

This block sits at the end of a pixel pipeline. On each pixel slot it receives one colour index from each of two background layers, the raw 4-bit colour of the sprite covering that pixel, and that sprite's attributes: a mirror bit for each axis, a 4-bit palette bank, a 2-bit depth code and a size code for each axis. It works out which texel of the sprite bitmap belongs to this pixel, taking the mirror bits and the sprite size into account. It also works out the sprite's full 8-bit colour index and decides which of the three sources is shown.

All results leave the block from one register stage, together with a valid flag and a code that names the winning source. Walking the sprite list, fetching the bitmap and turning the index into RGB are done by other blocks.

Top module: `sprite_pixel_mixer`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `out_pix`, `out_src`, `tex_x` and `tex_y` are all cleared to zero on that edge.
- R2: Every output is registered. The result for the inputs sampled at one rising edge appears right after that edge, and `out_valid` equals `in_valid` from the previous edge.
- R3: When the sprite wins, `out_pix` equals 16 × `spr_pal` + `spr_raw`, with the bank in bits 7:4 and the raw colour in bits 3:0.
- R4: A sprite whose `spr_raw` is 0 is transparent and never wins, whatever its depth.
- R5: A layer pixel of index 0 is transparent. When no source is opaque, `out_pix` is 0 and `out_src` is 0 (none).
- R6: Depth code 0 disables the sprite. Only the layers compete.
- R7: Depth code 1 places the sprite behind both layers. It wins only when both layer pixels are 0.
- R8: Depth code 2 places the sprite above layer 0 and below layer 1.
- R9: Depth code 3 places the sprite above both layers.
- R10: Layer 1 always covers layer 0. `out_src` encodes the winner as 0 none, 1 layer 0, 2 layer 1, 3 sprite.
- R11: The sprite width is W = 8 << `spr_wsize` (codes 0..3 give 8, 16, 32, 64). `tex_x` is `spr_x` mod W when `spr_hflip` is 0, and W−1−(`spr_x` mod W) when it is 1.
- R12: The sprite height is H = 8 << `spr_hsize`. `tex_y` is `spr_y` mod H when `spr_vflip` is 0, and H−1−(`spr_y` mod H) when it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel slot is valid |
| l0_pix | input | 8 | Layer 0 colour index, 0 = transparent |
| l1_pix | input | 8 | Layer 1 colour index, 0 = transparent |
| spr_raw | input | 4 | Raw sprite colour, 0 = transparent |
| spr_pal | input | 4 | Sprite palette bank |
| spr_depth | input | 2 | Sprite depth code |
| spr_hflip | input | 1 | Mirror left to right |
| spr_vflip | input | 1 | Mirror top to bottom |
| spr_wsize | input | 2 | Width code, width = 8 << code |
| spr_hsize | input | 2 | Height code, height = 8 << code |
| spr_x | input | 6 | Column within the sprite |
| spr_y | input | 6 | Row within the sprite |
| out_valid | output | 1 | Output slot valid |
| out_pix | output | 8 | Chosen colour index |
| out_src | output | 2 | Winning source code |
| tex_x | output | 6 | Texel column to fetch |
| tex_y | output | 6 | Texel row to fetch |

## Verification
A wrong depth ranking or a bad transparency test shows up as the wrong `out_src` and `out_pix` one cycle after the offending pixel is sampled. It only appears when the sprite and layer opacities combine in the way that exposes it. For this reason the stimulus sweeps every depth code against opaque and transparent layers. A bad mirror or size mask shows up as a wrong `tex_x` or `tex_y` in the same cycle. Nothing carries over between pixels, so each fault shows on the very next output and can be pinned to one input vector.

// File: rtl/spx_pkg.sv
package spx_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_L0   = 2'd1,
        SRC_L1   = 2'd2,
        SRC_SPR  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        DEP_OFF   = 2'd0,
        DEP_BACK  = 2'd1,
        DEP_MID   = 2'd2,
        DEP_FRONT = 2'd3
    } depth_e;

    // Largest index that fits a sprite axis of size 8 << code.
    function automatic logic [6:0] axis_mask(input logic [1:0] code);
        logic [6:0] sz;
        sz = 7'd8 << code;
        return sz - 7'd1;
    endfunction

endpackage

// File: rtl/spx_axis_flip.sv
module spx_axis_flip #(
    parameter int COORD_W = 6
) (
    input  logic [COORD_W-1:0] pos,
    input  logic [1:0]         size_code,
    input  logic               mirror,
    output logic [COORD_W-1:0] texel
);
    import spx_pkg::*;

    logic [6:0]         full_mask;
    logic [COORD_W-1:0] mask;
    logic [COORD_W-1:0] folded;

    always_comb begin
        full_mask = axis_mask(size_code);
        mask      = full_mask[COORD_W-1:0];
        folded    = pos & mask;
        texel     = mirror ? (mask - folded) : folded;
    end
endmodule

// File: rtl/spx_color_remap.sv
module spx_color_remap #(
    parameter int RAW_W = 4,
    parameter int PAL_W = 4
) (
    input  logic [RAW_W-1:0]       raw,
    input  logic [PAL_W-1:0]       bank,
    output logic [PAL_W+RAW_W-1:0] idx,
    output logic                   opaque
);
    always_comb begin
        opaque = (raw != '0);
        idx    = {bank, raw};
    end
endmodule

// File: rtl/spx_prio_select.sv
module spx_prio_select #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] l0,
    input  logic [IDX_W-1:0] l1,
    input  logic [IDX_W-1:0] spr,
    input  logic             spr_opaque,
    input  spx_pkg::depth_e  depth,
    output logic [IDX_W-1:0] pix,
    output spx_pkg::src_e    src
);
    import spx_pkg::*;

    logic l0_on, l1_on, s_on;

    always_comb begin
        l0_on = (l0 != '0);
        l1_on = (l1 != '0);
        s_on  = spr_opaque && (depth != DEP_OFF);
        pix   = '0;
        src   = SRC_NONE;
        unique case (depth)
            DEP_FRONT: begin
                if (s_on)       begin pix = spr; src = SRC_SPR; end
                else if (l1_on) begin pix = l1;  src = SRC_L1;  end
                else if (l0_on) begin pix = l0;  src = SRC_L0;  end
            end
            DEP_MID: begin
                if (l1_on)      begin pix = l1;  src = SRC_L1;  end
                else if (s_on)  begin pix = spr; src = SRC_SPR; end
                else if (l0_on) begin pix = l0;  src = SRC_L0;  end
            end
            DEP_BACK: begin
                if (l1_on)      begin pix = l1;  src = SRC_L1;  end
                else if (l0_on) begin pix = l0;  src = SRC_L0;  end
                else if (s_on)  begin pix = spr; src = SRC_SPR; end
            end
            default: begin
                if (l1_on)      begin pix = l1;  src = SRC_L1;  end
                else if (l0_on) begin pix = l0;  src = SRC_L0;  end
            end
        endcase
    end
endmodule

// File: rtl/sprite_pixel_mixer.sv
module sprite_pixel_mixer #(
    parameter int COORD_W = 6,
    parameter int RAW_W   = 4,
    parameter int PAL_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic [PAL_W+RAW_W-1:0]   l0_pix,
    input  logic [PAL_W+RAW_W-1:0]   l1_pix,
    input  logic [RAW_W-1:0]         spr_raw,
    input  logic [PAL_W-1:0]         spr_pal,
    input  logic [1:0]               spr_depth,
    input  logic                     spr_hflip,
    input  logic                     spr_vflip,
    input  logic [1:0]               spr_wsize,
    input  logic [1:0]               spr_hsize,
    input  logic [COORD_W-1:0]       spr_x,
    input  logic [COORD_W-1:0]       spr_y,
    output logic                     out_valid,
    output logic [PAL_W+RAW_W-1:0]   out_pix,
    output logic [1:0]               out_src,
    output logic [COORD_W-1:0]       tex_x,
    output logic [COORD_W-1:0]       tex_y
);
    import spx_pkg::*;

    localparam int IDX_W = PAL_W + RAW_W;
    localparam int N_AXIS = 2;

    logic [IDX_W-1:0]   spr_idx;
    logic               spr_opaque;
    logic [IDX_W-1:0]   mix_pix;
    src_e               mix_src;
    logic [COORD_W-1:0] ax_pos  [N_AXIS];
    logic [1:0]         ax_size [N_AXIS];
    logic               ax_mir  [N_AXIS];
    logic [COORD_W-1:0] ax_tex  [N_AXIS];

    spx_color_remap #(.RAW_W(RAW_W), .PAL_W(PAL_W)) u_remap (
        .raw    (spr_raw),
        .bank   (spr_pal),
        .idx    (spr_idx),
        .opaque (spr_opaque)
    );

    spx_prio_select #(.IDX_W(IDX_W)) u_prio (
        .l0         (l0_pix),
        .l1         (l1_pix),
        .spr        (spr_idx),
        .spr_opaque (spr_opaque),
        .depth      (depth_e'(spr_depth)),
        .pix        (mix_pix),
        .src        (mix_src)
    );

    always_comb begin
        ax_pos[0]  = spr_x;     ax_pos[1]  = spr_y;
        ax_size[0] = spr_wsize; ax_size[1] = spr_hsize;
        ax_mir[0]  = spr_hflip; ax_mir[1]  = spr_vflip;
    end

    for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
        spx_axis_flip #(.COORD_W(COORD_W)) u_flip (
            .pos       (ax_pos[a]),
            .size_code (ax_size[a]),
            .mirror    (ax_mir[a]),
            .texel     (ax_tex[a])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
            out_src   <= SRC_NONE;
            tex_x     <= '0;
            tex_y     <= '0;
        end else begin
            out_valid <= in_valid;
            out_pix   <= mix_pix;
            out_src   <= mix_src;
            tex_x     <= ax_tex[0];
            tex_y     <= ax_tex[1];
        end
    end

    // R2: valid follows the input by exactly one cycle
    p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> out_valid == $past(in_valid));

    // R5: nothing opaque means index zero
    p_none_is_zero_r5: assert property (@(posedge clk) disable iff (rst)
        out_src == SRC_NONE |-> out_pix == '0);

    // R4: a shown sprite never has raw colour zero
    p_sprite_opaque_r4: assert property (@(posedge clk) disable iff (rst)
        out_src == SRC_SPR |-> out_pix[RAW_W-1:0] != '0);

    // R9: a front sprite with an opaque colour always wins
    p_front_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(spr_depth) == 2'd3 && $past(spr_raw) != '0)
        |-> out_src == SRC_SPR);

    // R11: the column stays inside the sprite width
    p_tex_x_range_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> {1'b0, tex_x} <= axis_mask($past(spr_wsize)));

    // R6: a disabled sprite is never shown
    p_off_hidden_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(spr_depth) == 2'd0) |-> out_src != SRC_SPR);
endmodule

// File: tb/sprite_pixel_mixer_bench.sv
module sprite_pixel_mixer_bench;

    typedef struct packed {
        logic [7:0] l0;
        logic [7:0] l1;
        logic [3:0] raw;
        logic [3:0] pal;
        logic [1:0] dep;
        logic       hf;
        logic       vf;
        logic [1:0] ws;
        logic [1:0] hs;
        logic [5:0] x;
        logic [5:0] y;
        logic [7:0] e_pix;
        logic [1:0] e_src;
        logic [5:0] e_tx;
        logic [5:0] e_ty;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        // R9 R3: front sprite over layer 0
        '{8'h11, 8'h00, 4'h5, 4'h2, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 6'd3, 6'd4, 8'h25, 2'd3, 6'd3, 6'd4},
        // R9: front sprite over both layers
        '{8'h11, 8'h22, 4'h5, 4'h2, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 6'd3, 6'd4, 8'h25, 2'd3, 6'd3, 6'd4},
        // R8: mid sprite under layer 1
        '{8'h11, 8'h22, 4'h7, 4'h1, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'h22, 2'd2, 6'd0, 6'd0},
        // R8: mid sprite over layer 0
        '{8'h11, 8'h00, 4'h7, 4'h1, 2'd2, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'h17, 2'd3, 6'd0, 6'd0},
        // R7: back sprite under layer 0
        '{8'h11, 8'h00, 4'h7, 4'h1, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'h11, 2'd1, 6'd0, 6'd0},
        // R7 R3: back sprite shown through empty layers
        '{8'h00, 8'h00, 4'h9, 4'hF, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'hF9, 2'd3, 6'd0, 6'd0},
        // R6 R5: disabled sprite, empty layers
        '{8'h00, 8'h00, 4'h9, 4'hF, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'h00, 2'd0, 6'd0, 6'd0},
        // R4: transparent front sprite
        '{8'h33, 8'h00, 4'h0, 4'h5, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'h33, 2'd1, 6'd0, 6'd0},
        // R5 R4: everything transparent
        '{8'h00, 8'h00, 4'h0, 4'h5, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'h00, 2'd0, 6'd0, 6'd0},
        // R10 R6: layer 1 covers layer 0
        '{8'h33, 8'h44, 4'h6, 4'h5, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd0, 6'd0, 8'h44, 2'd2, 6'd0, 6'd0},
        // R11 R12: mirrored 16 wide, 32 high
        '{8'h00, 8'h00, 4'h1, 4'h0, 2'd3, 1'b1, 1'b1, 2'd1, 2'd2, 6'd3, 6'd5, 8'h01, 2'd3, 6'd12, 6'd26},
        // R11 R12: 64 by 64, vertical mirror only
        '{8'h00, 8'h00, 4'hF, 4'hF, 2'd3, 1'b0, 1'b1, 2'd3, 2'd3, 6'd63, 6'd0, 8'hFF, 2'd3, 6'd63, 6'd63},
        // R11 R12 R8: coordinates folded into an 8x8 sprite
        '{8'h50, 8'h00, 4'h2, 4'h3, 2'd2, 1'b1, 1'b0, 2'd0, 2'd0, 6'd10, 6'd9, 8'h32, 2'd3, 6'd5, 6'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] l0_pix = '0, l1_pix = '0;
    logic [3:0] spr_raw = '0, spr_pal = '0;
    logic [1:0] spr_depth = '0, spr_wsize = '0, spr_hsize = '0;
    logic       spr_hflip = 1'b0, spr_vflip = 1'b0;
    logic [5:0] spr_x = '0, spr_y = '0;
    logic       out_valid;
    logic [7:0] out_pix;
    logic [1:0] out_src;
    logic [5:0] tex_x, tex_y;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sprite_pixel_mixer u_sprite_pixel_mixer (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .l0_pix(l0_pix), .l1_pix(l1_pix), .spr_raw(spr_raw), .spr_pal(spr_pal),
        .spr_depth(spr_depth), .spr_hflip(spr_hflip), .spr_vflip(spr_vflip),
        .spr_wsize(spr_wsize), .spr_hsize(spr_hsize), .spr_x(spr_x), .spr_y(spr_y),
        .out_valid(out_valid), .out_pix(out_pix), .out_src(out_src),
        .tex_x(tex_x), .tex_y(tex_y)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        l0_pix = v.l0; l1_pix = v.l1; spr_raw = v.raw; spr_pal = v.pal;
        spr_depth = v.dep; spr_hflip = v.hf; spr_vflip = v.vf;
        spr_wsize = v.ws; spr_hsize = v.hs; spr_x = v.x; spr_y = v.y;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with busy inputs held during reset
        apply(VECS[1]);
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "out_valid", out_valid, 0);
        check("R1", "out_pix", out_pix, 0);
        check("R1", "out_src", out_src, 0);
        check("R1", "tex_x", tex_x, 0);
        check("R1", "tex_y", tex_y, 0);
        rst = 1'b0;
        in_valid = 1'b0;

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            apply(VECS[i]);
            in_valid = 1'b1;
            @(negedge clk);
            check("R2", $sformatf("v%0d out_valid", i), out_valid, 1);
            check("R3..R10", $sformatf("v%0d out_pix", i), out_pix, VECS[i].e_pix);
            check("R10", $sformatf("v%0d out_src", i), out_src, VECS[i].e_src);
            check("R11", $sformatf("v%0d tex_x", i), tex_x, VECS[i].e_tx);
            check("R12", $sformatf("v%0d tex_y", i), tex_y, VECS[i].e_ty);
        end

        // R2: valid tracks a gap of one cycle
        in_valid = 1'b0;
        apply(VECS[0]);
        @(negedge clk);
        check("R2", "gap out_valid", out_valid, 0);
        in_valid = 1'b1;
        apply(VECS[5]);
        @(negedge clk);
        check("R2", "resume out_valid", out_valid, 1);
        check("R2", "resume out_pix", out_pix, 8'hF9);

        // R1: reset in the middle of a stream clears everything
        rst = 1'b1;
        @(negedge clk);
        check("R1", "mid out_valid", out_valid, 0);
        check("R1", "mid out_pix", out_pix, 0);
        check("R1", "mid out_src", out_src, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule